// File: doc/BRIEF.md
# Nibble-Carry Adder and Flag Generator

This block is the combinational arithmetic path of a small 8-bit processor whose flag register records a half-carry between nibbles as well as a full carry. One operation select picks among an 8-bit accumulator add, a 16-bit register-pair add, a stack-pointer-plus-signed-offset add (two codes: one for the form that writes the stack pointer, one for the form that writes the pair register), a 16-bit increment, a 16-bit decrement and a decimal adjust after an add. The block returns the 16-bit result and the next value of the four flags. The current flags come in so that operations which keep some or all of them can pass them through.

One adder serves every arithmetic operation. It is built as a chain of nibble slices, and each slice's carry is exposed. Each operation then takes its half-carry and carry from the slice boundaries that suit it. The decimal adjust runs on a separate small path that reads the incoming half-carry and carry.

Top module: `gbf_alu_flags`

## Requirements
- R1: Flags are packed as bit 3 = Z (zero), bit 2 = N (subtract), bit 1 = H (half-carry), bit 0 = C (carry). Operation codes are 0 = 8-bit add, 1 = 16-bit add, 2 = SP plus offset, 3 = HL from SP plus offset, 4 = increment, 5 = decrement, 6 = decimal adjust, 7 = reserved.
- R2: The 8-bit add returns (opa[7:0]+opb[7:0]) mod 256 in result[7:0] and zero in result[15:8]. Z is set exactly when that byte is zero, and N is cleared.
- R3: The 8-bit add sets H exactly when the low nibbles of the operands sum above 0xF, and sets C exactly when the bytes sum above 0xFF.
- R4: The 16-bit add returns (opa+opb) mod 65536. H is the carry from bit 11 into bit 12 and C is the carry out of bit 15.
- R5: The 16-bit add keeps Z from the incoming flags and clears N.
- R6: Both offset codes (2 and 3) return (opa + sign-extended opb[7:0]) mod 65536, and the two codes give identical outputs.
- R7: Both offset codes take H from the low-nibble carry and C from the low-byte carry of the unsigned opa[7:0]+opb[7:0], and clear Z and N.
- R8: Increment and decrement return opa+1 and opa-1 modulo 65536 (wrapping at 0xFFFF and 0x0000) and return the incoming flags unchanged.
- R9: Decimal adjust adds 0x60 to opa[7:0] and sets C when incoming C is set or opa[7:0] > 0x99, otherwise it keeps C clear. It adds 0x06 when incoming H is set or opa[3:0] > 9. The sum is taken modulo 256.
- R10: Decimal adjust clears H, keeps N, sets Z exactly when the adjusted byte is zero, and returns zero in result[15:8].
- R11: The reserved code returns opa unchanged and passes the flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (R1) |
| opa | input | 16 | First operand: accumulator, HL or SP |
| opb | input | 16 | Second operand; the low byte is the offset for codes 2 and 3 |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | 16 | Operation result |
| flags_out | output | 4 | Next flags {Z,N,H,C} |

## Verification
The 8-bit add and the decimal adjust are swept over every operand byte, and the decimal adjust is swept under all four combinations of incoming H and C. A design that took the half-carry from the wrong slice boundary would then show up on the operand pairs that carry in one nibble but not in another. The offset sweep covers all 256 offsets and includes negative offsets whose low-byte add carries even though the 16-bit result shrinks. A design that took the flags from the sign-extended sum, or from the high byte, would disagree there. Increment and decrement are driven across the 0xFFFF and 0x0000 wrap with every flag pattern, so a path that disturbed any flag would be caught. The 16-bit add is run with Z both set and clear, to catch a design that recomputes Z.

// File: rtl/gbf_pkg.sv
package gbf_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned SLICES  = DATA_W / NIB_W;

    typedef enum logic [2:0] {
        OP_ADD8    = 3'd0,
        OP_ADD16   = 3'd1,
        OP_SPOFS   = 3'd2,
        OP_HLSPOFS = 3'd3,
        OP_INC16   = 3'd4,
        OP_DEC16   = 3'd5,
        OP_DECADJ  = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic logic [DATA_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
        return {{(DATA_W-BYTE_W){v[BYTE_W-1]}}, v};
    endfunction

    function automatic logic is_sp_form(input op_e op);
        return (op == OP_SPOFS) || (op == OP_HLSPOFS);
    endfunction

endpackage

// File: rtl/gbf_nib_chain.sv
module gbf_nib_chain #(
    parameter int unsigned W   = 16,
    parameter int unsigned NIB = 4
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     sum,
    output logic [W/NIB:0]   carry
);
    localparam int unsigned NS = W / NIB;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < NS; g++) begin : g_slice
        assign {carry[g+1], sum[g*NIB +: NIB]} =
            {1'b0, a[g*NIB +: NIB]} + {1'b0, b[g*NIB +: NIB]} + {{NIB{1'b0}}, carry[g]};
    end

endmodule

// File: rtl/gbf_flag_sel.sv
module gbf_flag_sel
    import gbf_pkg::*;
(
    input  op_e                 op,
    input  logic [SLICES:0]     carry,
    input  logic [BYTE_W-1:0]   sum_lo,
    input  flags_t              fin,
    output flags_t              fout
);
    always_comb begin
        fout = fin;
        unique case (op)
            OP_ADD8: begin
                fout.z = (sum_lo == '0);
                fout.n = 1'b0;
                fout.h = carry[1];
                fout.c = carry[2];
            end
            OP_ADD16: begin
                fout.n = 1'b0;
                fout.h = carry[SLICES-1];
                fout.c = carry[SLICES];
            end
            OP_SPOFS, OP_HLSPOFS: begin
                fout.z = 1'b0;
                fout.n = 1'b0;
                fout.h = carry[1];
                fout.c = carry[2];
            end
            default: fout = fin;
        endcase
    end

endmodule

// File: rtl/gbf_decadj.sv
module gbf_decadj
    import gbf_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic              h_in,
    input  logic              c_in,
    output logic [BYTE_W-1:0] r,
    output logic              c_out
);
    logic [BYTE_W-1:0] corr;
    logic              hi_fix;
    logic              lo_fix;

    always_comb begin
        hi_fix = c_in || (a > 8'h99);
        lo_fix = h_in || (a[NIB_W-1:0] > 4'd9);
        corr   = {hi_fix ? 4'h6 : 4'h0, lo_fix ? 4'h6 : 4'h0};
        r      = a + corr;
        c_out  = hi_fix;
    end

    always_comb begin
        if (c_in) begin
            AST_DADJ_CARRY_STICKY: assert (c_out) else $error("carry dropped"); // R9
        end
    end

endmodule

// File: rtl/gbf_alu_flags.sv
module gbf_alu_flags
    import gbf_pkg::*;
(
    input  logic [2:0]        op_sel,
    input  logic [15:0]       opa,
    input  logic [15:0]       opb,
    input  logic [3:0]        flags_in,
    output logic [15:0]       result,
    output logic [3:0]        flags_out
);
    op_e               op;
    flags_t            fin;
    flags_t            fadd;
    flags_t            fres;
    logic [DATA_W-1:0] add_a;
    logic [DATA_W-1:0] add_b;
    logic [DATA_W-1:0] add_sum;
    logic [SLICES:0]   add_carry;
    logic [BYTE_W-1:0] da_r;
    logic              da_c;

    assign op  = op_e'(op_sel);
    assign fin = flags_t'(flags_in);

    always_comb begin
        unique case (op)
            OP_ADD8: begin
                add_a = {{(DATA_W-BYTE_W){1'b0}}, opa[BYTE_W-1:0]};
                add_b = {{(DATA_W-BYTE_W){1'b0}}, opb[BYTE_W-1:0]};
            end
            OP_ADD16: begin
                add_a = opa;
                add_b = opb;
            end
            OP_SPOFS, OP_HLSPOFS: begin
                add_a = opa;
                add_b = sext_byte(opb[BYTE_W-1:0]);
            end
            OP_INC16: begin
                add_a = opa;
                add_b = DATA_W'(1);
            end
            OP_DEC16: begin
                add_a = opa;
                add_b = '1;
            end
            default: begin
                add_a = opa;
                add_b = '0;
            end
        endcase
    end

    gbf_nib_chain #(.W(DATA_W), .NIB(NIB_W)) u_chain (
        .a     (add_a),
        .b     (add_b),
        .sum   (add_sum),
        .carry (add_carry)
    );

    gbf_flag_sel u_fsel (
        .op     (op),
        .carry  (add_carry),
        .sum_lo (add_sum[BYTE_W-1:0]),
        .fin    (fin),
        .fout   (fadd)
    );

    gbf_decadj u_dadj (
        .a     (opa[BYTE_W-1:0]),
        .h_in  (fin.h),
        .c_in  (fin.c),
        .r     (da_r),
        .c_out (da_c)
    );

    always_comb begin
        if (op == OP_DECADJ) begin
            result = {{(DATA_W-BYTE_W){1'b0}}, da_r};
            fres   = '{z: (da_r == '0), n: fin.n, h: 1'b0, c: da_c};
        end else if (op == OP_ADD8) begin
            result = {{(DATA_W-BYTE_W){1'b0}}, add_sum[BYTE_W-1:0]};
            fres   = fadd;
        end else begin
            result = add_sum;
            fres   = fadd;
        end
    end

    assign flags_out = fres;

    always_comb begin
        if (op == OP_INC16 || op == OP_DEC16 || op == OP_RSVD) begin
            AST_KEEP_FLAGS: assert (flags_out == flags_in) else $error("flags moved"); // R8
        end
        if (op == OP_ADD16) begin
            AST_ADD16_ZN: assert (flags_out[3] == flags_in[3] && !flags_out[2]) else $error("add16 Z/N"); // R5
        end
        if (is_sp_form(op)) begin
            AST_SPOFS_ZN: assert (flags_out[3:2] == 2'b00) else $error("offset Z/N"); // R7
        end
        if (op == OP_ADD8) begin
            AST_ADD8_HIGH: assert (result[15:8] == 8'h00) else $error("add8 high byte"); // R2
        end
        if (op == OP_DECADJ) begin
            AST_DADJ_HCLR: assert (!flags_out[1] && result[15:8] == 8'h00) else $error("dadj H"); // R10
        end
    end

endmodule

// File: tb/sim_gbf_alu_flags.sv
module sim_gbf_alu_flags;

    logic        clk = 1'b0;
    logic [2:0]  op_sel;
    logic [15:0] opa;
    logic [15:0] opb;
    logic [3:0]  flags_in;
    logic [15:0] result;
    logic [3:0]  flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gbf_alu_flags u0 (
        .op_sel    (op_sel),
        .opa       (opa),
        .opb       (opb),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    task automatic apply(input int op, input int a, input int b, input int f);
        op_sel   = op[2:0];
        opa      = a[15:0];
        opb      = b[15:0];
        flags_in = f[3:0];
        #1;
    endtask

    task automatic chk(input string req, input int er, input int ef);
        checks++;
        if (result !== er[15:0] || flags_out !== ef[3:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h fin=%b : got r=%h f=%b, expected r=%h f=%b",
                     req, op_sel, opa, opb, flags_in, result, flags_out, er[15:0], ef[3:0]);
        end
    endtask

    function automatic int pk(input int z, input int n, input int h, input int c);
        return ((z & 1) << 3) | ((n & 1) << 2) | ((h & 1) << 1) | (c & 1);
    endfunction

    initial begin : main
        int seed = 32'h1234_5678;
        int r, h, c, z, sx, f, corr, a8;

        // R1: code 0 with zero operands gives Z only
        apply(0, 0, 0, 4'b0111);
        chk("R1", 0, 4'b1000);

        // R2 R3: exhaustive 8-bit add, upper operand bytes set to junk
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                f = (a ^ b) & 15;
                apply(0, a | 16'hA500, b | 16'h5A00, f);
                r = (a + b) & 255;
                h = (((a & 15) + (b & 15)) > 15) ? 1 : 0;
                c = ((a + b) > 255) ? 1 : 0;
                chk("R2_R3", r, pk(r == 0, 0, h, c));
            end
        end

        // R4 R5: 16-bit add, pseudo-random plus edges
        for (int i = 0; i < 4096; i++) begin
            int a, b;
            seed = seed * 1103515245 + 12345;
            a = (seed >>> 8) & 16'hFFFF;
            seed = seed * 1103515245 + 12345;
            b = (seed >>> 8) & 16'hFFFF;
            if (i == 0) begin a = 16'h0FFF; b = 16'h0001; end
            if (i == 1) begin a = 16'hFFFF; b = 16'h0001; end
            if (i == 2) begin a = 16'h1000; b = 16'h2000; end
            f = i & 15;
            apply(1, a, b, f);
            r = (a + b) & 16'hFFFF;
            h = (((a & 16'hFFF) + (b & 16'hFFF)) > 16'hFFF) ? 1 : 0;
            c = ((a + b) > 16'hFFFF) ? 1 : 0;
            chk("R4_R5", r, pk((f >> 3) & 1, 0, h, c));
        end

        // R6 R7: all offsets, both codes
        for (int s = 0; s < 24; s++) begin
            int sp;
            seed = seed * 1103515245 + 12345;
            sp = (s == 0) ? 16'h0000 : (s == 1) ? 16'hFFFF : (s == 2) ? 16'h00FF : ((seed >>> 8) & 16'hFFFF);
            for (int o = 0; o < 256; o++) begin
                sx = (o > 127) ? (o | 16'hFF00) : o;
                r  = (sp + sx) & 16'hFFFF;
                h  = (((sp & 15) + (o & 15)) > 15) ? 1 : 0;
                c  = (((sp & 255) + o) > 255) ? 1 : 0;
                apply(2, sp, o | 16'h3300, 4'b1111);
                chk("R6_R7_sp", r, pk(0, 0, h, c));
                apply(3, sp, o, 4'b0000);
                chk("R6_R7_hl", r, pk(0, 0, h, c));
            end
        end

        // R8: increment/decrement across wraps, every flag pattern
        for (int i = 0; i < 512; i++) begin
            int a;
            a = (i < 16) ? 16'hFFFF : (i < 32) ? 16'h0000 : ((i * 16'h9E37) & 16'hFFFF);
            f = i & 15;
            apply(4, a, 16'h1234, f);
            chk("R8_inc", (a + 1) & 16'hFFFF, f);
            apply(5, a, 16'h1234, f);
            chk("R8_dec", (a - 1) & 16'hFFFF, f);
        end

        // R9 R10: exhaustive decimal adjust
        for (int a = 0; a < 256; a++) begin
            for (int hc = 0; hc < 8; hc++) begin
                int hi, ci, ni;
                ci = hc & 1; hi = (hc >> 1) & 1; ni = (hc >> 2) & 1;
                corr = 0; c = 0;
                if (ci == 1 || a > 16'h99) begin corr = corr + 16'h60; c = 1; end
                if (hi == 1 || (a & 15) > 9) corr = corr + 6;
                a8 = (a + corr) & 255;
                apply(6, a | 16'hC300, 16'h0000, pk(1, ni, hi, ci));
                chk("R9_R10", a8, pk(a8 == 0, ni, 0, c));
            end
        end

        // R11: reserved code
        for (int i = 0; i < 64; i++) begin
            int a;
            a = (i * 16'h3F1D) & 16'hFFFF;
            apply(7, a, 16'hFFFF, i & 15);
            chk("R11", a, i & 15);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule